// File: doc/BRIEF.md
# Sixteen-Channel DAC Register Controller

This block keeps the digital state behind a sixteen-channel digital-to-analog converter. Each channel owns two input registers (A and B), a select bit, a live output register, and a sleep flag. A serial front end delivers each 32-bit command word with a chip-select line. The command is taken when chip-select rises. Inside the word, bits [23:20] hold the operation, bits [19:16] hold the channel, and bits [15:0] hold the data. Bits [31:24] are not used.

A separate active-low load pin, which may arrive asynchronously, acts on all channels at once. What it does depends on whether a frame is open. Leaving a sleep state starts a busy window. This window is longer after a whole-chip sleep than after a single-channel sleep, and both lengths scale with the clock-frequency parameter `CLK_MHZ`.

The outputs are each channel's 16-bit code, an enable for each channel, and the busy flag.

Top module: `dac_reg_ctrl`

## Requirements
- R1: Operation 4'b0000 writes the data into register A of the addressed channel when its select bit is 0, and into register B when the select bit is 1. The output code does not change.
- R2: Operation 4'b0001 copies the register picked by the channel's select bit (A for 0, B for 1) into the output. Operation 4'b0011 does the write and then this copy, in the same cycle.
- R3: Operation 4'b0110 loads all select bits from the data field. Data bit i goes to channel i.
- R4: Operation 4'b0111 updates every output. A channel with select 0 takes A. A channel with select 1 takes B when data bit 0 is 1, and A when it is 0.
- R5: Operation 4'b0100 puts the addressed channel to sleep. Operation 4'b0101 puts every channel to sleep. Enable is the inverse of the sleep flag. Sleep ignores the data field and keeps every code and register.
- R6: Any output update clears the sleep flag of each channel it touches. This covers per-channel updates, the toggle, and the load pin.
- R7: When a channel wakes, busy goes high for 30*CLK_MHZ cycles. If the last sleep was a whole-chip sleep, it goes high for 35*CLK_MHZ cycles instead.
- R8: The load pin held low while chip-select is high makes every output copy its selected input register.
- R9: A low pulse on the load pin inside an open frame wakes every channel and changes no code.
- R10: If the load pin is still low when chip-select rises, the framed command runs first and then every output updates.
- R11: After reset, all codes are 0, every channel is enabled, and busy is 0.
- R12: Operation 4'b1111 and every operation code not listed above change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Frame select from the serial front end, active low; the command is taken on its rise |
| cmd_word | input | 32 | Decoded command word |
| load_n | input | 1 | Asynchronous active-low load-all pin |
| dac_code | output | NCH*16 | Output codes, channel i at bits [16*i+15:16*i] |
| out_en | output | NCH | Enable for each channel |
| busy | output | 1 | Wake-up delay in progress |

## Verification
The output-update path is driven in several ways: plain writes followed by a separate update, a combined write-and-update, a toggle with data bit 0 clear and then set, and a load pin asserted outside a frame. Each of these pulls from a different mix of A and B, so swapping the registers or misreading a select bit gives a wrong code. The sleep tests cover a single-channel sleep and a whole-chip sleep. Each is then woken, and the busy window is measured, which separates the two delay lengths. Pulsing the load pin inside a frame is compared with holding it low across the chip-select rise. This separates "wake only" from "execute, then update all".

// File: rtl/dac_ctrl_pkg.sv
package dac_ctrl_pkg;

    localparam int DATA_W   = 16;
    localparam int WORD_W   = 32;
    localparam int OP_LSB   = 20;
    localparam int ADDR_LSB = 16;

    typedef enum logic [3:0] {
        OP_WRITE   = 4'b0000,
        OP_UPDATE  = 4'b0001,
        OP_WR_UPD  = 4'b0011,
        OP_PD_CH   = 4'b0100,
        OP_PD_CHIP = 4'b0101,
        OP_SEL     = 4'b0110,
        OP_TOGGLE  = 4'b0111,
        OP_NOP     = 4'b1111
    } op_e;

    typedef struct packed {
        logic              valid;
        logic [3:0]        op;
        logic [3:0]        addr;
        logic [DATA_W-1:0] data;
    } cmd_s;

    function automatic cmd_s split_word(input logic [WORD_W-1:0] w, input logic v);
        cmd_s c;
        c.valid = v;
        c.op    = w[OP_LSB +: 4];
        c.addr  = w[ADDR_LSB +: 4];
        c.data  = w[DATA_W-1:0];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] pick_src(input logic sel,
                                                   input logic [DATA_W-1:0] a,
                                                   input logic [DATA_W-1:0] b);
        return sel ? b : a;
    endfunction

endpackage

// File: rtl/dac_load_sync.sv
module dac_load_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic load_n,
    input  logic cs_n,
    output logic load_lo,
    output logic load_fall
);
    logic [STAGES-1:0] shreg;
    logic              lo_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '1;
            lo_d  <= 1'b0;
        end else begin
            shreg <= {shreg[STAGES-2:0], load_n};
            lo_d  <= load_lo;
        end
    end

    assign load_lo   = ~shreg[STAGES-1];
    assign load_fall = load_lo & ~lo_d & ~cs_n;
endmodule

// File: rtl/dac_cmd_capture.sv
module dac_cmd_capture
    import dac_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic [WORD_W-1:0] cmd_word,
    output cmd_s              cmd
);
    logic cs_q;
    logic unused_hi;

    always_ff @(posedge clk) begin
        if (rst) cs_q <= 1'b1;
        else     cs_q <= cs_n;
    end

    assign unused_hi = ^cmd_word[WORD_W-1:OP_LSB+4];
    assign cmd       = split_word(cmd_word, cs_n & ~cs_q);
endmodule

// File: rtl/dac_wake_timer.sv
module dac_wake_timer #(
    parameter int CH_CYC   = 1500,
    parameter int CHIP_CYC = 1750
) (
    input  logic clk,
    input  logic rst,
    input  logic wake,
    input  logic chip_mode,
    output logic busy
);
    localparam int MAXC = (CH_CYC > CHIP_CYC) ? CH_CYC : CHIP_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (wake)       cnt <= chip_mode ? CW'(CHIP_CYC) : CW'(CH_CYC);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/dac_reg_ctrl.sv
module dac_reg_ctrl
    import dac_ctrl_pkg::*;
#(
    parameter int NCH     = 16,
    parameter int CLK_MHZ = 50
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cs_n,
    input  logic [WORD_W-1:0]     cmd_word,
    input  logic                  load_n,
    output logic [NCH*DATA_W-1:0] dac_code,
    output logic [NCH-1:0]        out_en,
    output logic                  busy
);
    localparam int AW       = $clog2(NCH);
    localparam int CH_CYC   = 30 * CLK_MHZ;
    localparam int CHIP_CYC = 35 * CLK_MHZ;

    cmd_s             cmd;
    logic             load_lo, load_fall, load_all, wake;
    logic [3:0]       cmd_op;
    logic [3:0]       cmd_addr;
    logic             cmd_v;

    logic [DATA_W-1:0] a_q [NCH];
    logic [DATA_W-1:0] b_q [NCH];
    logic [DATA_W-1:0] d_q [NCH];
    logic [DATA_W-1:0] a_n [NCH];
    logic [DATA_W-1:0] b_n [NCH];
    logic [DATA_W-1:0] d_n [NCH];
    logic [NCH-1:0]    sel_q, sel_n, pd_q, pd_n;
    logic              chip_pd_q, chip_pd_n;

    dac_cmd_capture u_cap (.clk(clk), .rst(rst), .cs_n(cs_n), .cmd_word(cmd_word), .cmd(cmd));

    dac_load_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .load_n(load_n), .cs_n(cs_n),
        .load_lo(load_lo), .load_fall(load_fall)
    );

    assign cmd_v    = cmd.valid;
    assign cmd_op   = cmd.op;
    assign cmd_addr = cmd.addr;
    assign load_all = load_lo & cs_n;

    always_comb begin
        sel_n     = sel_q;
        pd_n      = pd_q;
        chip_pd_n = chip_pd_q;
        if (cmd.valid) begin
            case (cmd.op)
                OP_SEL:     sel_n = cmd.data[NCH-1:0];
                OP_PD_CHIP: begin pd_n = '1; chip_pd_n = 1'b1; end
                default:    ;
            endcase
        end
        for (int i = 0; i < NCH; i++) begin
            logic hit;
            hit    = cmd.valid && (cmd.addr[AW-1:0] == AW'(i));
            a_n[i] = a_q[i];
            b_n[i] = b_q[i];
            d_n[i] = d_q[i];
            if (hit && (cmd.op == OP_WRITE || cmd.op == OP_WR_UPD)) begin
                if (sel_q[i]) b_n[i] = cmd.data;
                else          a_n[i] = cmd.data;
            end
            if (hit && cmd.op == OP_PD_CH) pd_n[i] = 1'b1;
            if (hit && (cmd.op == OP_UPDATE || cmd.op == OP_WR_UPD)) begin
                d_n[i]  = pick_src(sel_n[i], a_n[i], b_n[i]);
                pd_n[i] = 1'b0;
            end
            if (cmd.valid && cmd.op == OP_TOGGLE) begin
                d_n[i]  = pick_src(sel_q[i] & cmd.data[0], a_n[i], b_n[i]);
                pd_n[i] = 1'b0;
            end
            if (load_all) begin
                d_n[i]  = pick_src(sel_n[i], a_n[i], b_n[i]);
                pd_n[i] = 1'b0;
            end
            if (load_fall) pd_n[i] = 1'b0;
        end
        wake = |(pd_q & ~pd_n);
        if (wake) chip_pd_n = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q     <= '0;
            pd_q      <= '0;
            chip_pd_q <= 1'b0;
            for (int i = 0; i < NCH; i++) begin
                a_q[i] <= '0;
                b_q[i] <= '0;
                d_q[i] <= '0;
            end
        end else begin
            sel_q     <= sel_n;
            pd_q      <= pd_n;
            chip_pd_q <= chip_pd_n;
            for (int i = 0; i < NCH; i++) begin
                a_q[i] <= a_n[i];
                b_q[i] <= b_n[i];
                d_q[i] <= d_n[i];
            end
        end
    end

    dac_wake_timer #(.CH_CYC(CH_CYC), .CHIP_CYC(CHIP_CYC)) u_wake (
        .clk(clk), .rst(rst), .wake(wake), .chip_mode(chip_pd_q), .busy(busy)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_out
        assign dac_code[g*DATA_W +: DATA_W] = d_q[g];
        assign out_en[g]                    = ~pd_q[g];
    end
endmodule

// File: rtl/dac_reg_ctrl_chk.sv
module dac_reg_ctrl_chk #(
    parameter int NCH = 16,
    parameter int DW  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_v,
    input logic [3:0]        cmd_op,
    input logic [3:0]        cmd_addr,
    input logic              load_lo,
    input logic              load_fall,
    input logic              wake,
    input logic [NCH*DW-1:0] dac_code,
    input logic [NCH-1:0]    out_en,
    input logic              busy
);
    localparam int AW = $clog2(NCH);
    logic [AW-1:0] ch;
    assign ch = cmd_addr[AW-1:0];

    p_pd_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd_v && cmd_op == 4'b0100 && !load_lo) |=> ($stable(dac_code) && !out_en[$past(ch)]));

    p_chip_off_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd_v && cmd_op == 4'b0101 && !load_lo) |=> (out_en == '0));

    p_upd_on_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_v && cmd_op == 4'b0001) |=> out_en[$past(ch)]);

    p_wake_busy_r7: assert property (@(posedge clk) disable iff (rst)
        wake |=> busy);

    p_frame_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        load_fall |=> (out_en == '1 && $stable(dac_code)));

    p_nop_still_r12: assert property (@(posedge clk) disable iff (rst)
        (cmd_v && cmd_op == 4'b1111 && !load_lo && !load_fall) |=> ($stable(dac_code) && $stable(out_en)));
endmodule

bind dac_reg_ctrl dac_reg_ctrl_chk #(.NCH(NCH), .DW(16)) u_chk (
    .clk(clk), .rst(rst), .cmd_v(cmd_v), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .load_lo(load_lo), .load_fall(load_fall), .wake(wake),
    .dac_code(dac_code), .out_en(out_en), .busy(busy)
);

// File: tb/dac_reg_ctrl_tb_top.sv
module dac_reg_ctrl_tb_top;
    localparam int NCH = 16;
    localparam int DW  = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cs_n = 1'b1;
    logic [31:0]       cmd_word = '0;
    logic              load_n = 1'b1;
    logic [NCH*DW-1:0] dac_code;
    logic [NCH-1:0]    out_en;
    logic              busy;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    dac_reg_ctrl dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .cmd_word(cmd_word), .load_n(load_n),
        .dac_code(dac_code), .out_en(out_en), .busy(busy)
    );

    function automatic logic [15:0] code(input int i);
        return dac_code[i*DW +: DW];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [3:0] op, input logic [3:0] addr, input logic [15:0] data);
        @(negedge clk);
        cmd_word = {8'h00, op, addr, data};
        cs_n = 1'b0;
        @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic measure_busy(output int n);
        n = 0;
        while (busy && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        chk("R11 codes", {16'h0, code(0) | code(5) | code(15)}, 32'h0);
        chk("R11 enables", {16'h0, out_en}, 32'h0000ffff);
        chk("R11 busy", {31'h0, busy}, 32'h0);
    endtask

    task automatic t_write_update;
        send(4'b0000, 4'd3, 16'h1234);
        chk("R1 write no output change", {16'h0, code(3)}, 32'h0);
        send(4'b0001, 4'd3, 16'h0);
        chk("R2 update from A", {16'h0, code(3)}, 32'h1234);
        send(4'b0011, 4'd5, 16'hbeef);
        chk("R2 write and update", {16'h0, code(5)}, 32'hbeef);
    endtask

    task automatic t_select_toggle;
        send(4'b0110, 4'd0, 16'h0004);
        send(4'b0000, 4'd2, 16'haaaa);
        chk("R1 write to B keeps output", {16'h0, code(2)}, 32'h0);
        send(4'b0001, 4'd2, 16'h0);
        chk("R3 select picks B", {16'h0, code(2)}, 32'haaaa);
        send(4'b0000, 4'd1, 16'h1111);
        send(4'b0111, 4'd0, 16'h0000);
        chk("R4 toggle phase 0 ch2 takes A", {16'h0, code(2)}, 32'h0);
        chk("R4 toggle ch1 takes A", {16'h0, code(1)}, 32'h1111);
        send(4'b0111, 4'd0, 16'h0001);
        chk("R4 toggle phase 1 ch2 takes B", {16'h0, code(2)}, 32'haaaa);
        chk("R4 toggle phase 1 ch3 keeps A", {16'h0, code(3)}, 32'h1234);
    endtask

    task automatic t_channel_pd;
        int n;
        send(4'b0100, 4'd1, 16'hffff);
        chk("R5 channel asleep", {16'h0, out_en}, 32'h0000fffd);
        chk("R5 code kept", {16'h0, code(1)}, 32'h1111);
        send(4'b0001, 4'd1, 16'h0);
        chk("R6 update wakes", {31'h0, out_en[1]}, 32'h1);
        measure_busy(n);
        chk("R7 channel wake window", n, 32'd1500);
    endtask

    task automatic t_chip_pd;
        int n;
        send(4'b0101, 4'd0, 16'h1234);
        chk("R5 chip asleep", {16'h0, out_en}, 32'h0);
        chk("R5 chip codes kept", {code(5), code(2)}, {16'hbeef, 16'haaaa});
        send(4'b1111, 4'd5, 16'h5555);
        send(4'b1000, 4'd5, 16'h5555);
        chk("R12 nop and unknown", {code(5), out_en}, {16'hbeef, 16'h0});
        send(4'b0111, 4'd0, 16'h0000);
        chk("R6 toggle wakes all", {16'h0, out_en}, 32'h0000ffff);
        chk("R4 toggle after sleep", {code(2), code(1)}, {16'h0000, 16'h1111});
        measure_busy(n);
        chk("R7 chip wake window", n, 32'd1750);
    endtask

    task automatic t_load_idle;
        send(4'b0000, 4'd7, 16'h7777);
        chk("R1 ch7 not yet out", {16'h0, code(7)}, 32'h0);
        @(negedge clk);
        load_n = 1'b0;
        repeat (5) @(negedge clk);
        load_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R8 load while idle", {code(7), code(2)}, {16'h7777, 16'haaaa});
    endtask

    task automatic t_load_frame;
        int n;
        send(4'b0101, 4'd0, 16'h0);
        send(4'b0000, 4'd8, 16'h8888);
        @(negedge clk);
        cmd_word = {8'h00, 4'b1111, 4'd0, 16'h0};
        cs_n = 1'b0;
        load_n = 1'b0;
        repeat (4) @(negedge clk);
        load_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R9 pulse wakes all", {16'h0, out_en}, 32'h0000ffff);
        chk("R9 pulse no update", {16'h0, code(8)}, 32'h0);
        cs_n = 1'b1;
        @(negedge clk);
        measure_busy(n);
    endtask

    task automatic t_load_held;
        @(negedge clk);
        cmd_word = {8'h00, 4'b0000, 4'd9, 16'h9999};
        cs_n = 1'b0;
        load_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R10 held low no early update", {16'h0, code(9)}, 32'h0);
        cs_n = 1'b1;
        @(negedge clk);
        chk("R10 command then update", {code(9), code(8)}, {16'h9999, 16'h8888});
        load_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write_update();
        t_select_toggle();
        t_channel_pd();
        t_chip_pd();
        t_load_idle();
        t_load_frame();
        t_load_held();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule